// File: doc/BRIEF.md
# Transmit Descriptor Write-Back Scheduler

This block decides when finished transmit descriptors are reported back to host memory, and in what form. Each completion event stands for the next descriptor in ring order. It carries a report-status flag and a delay-enable flag. The block keeps the range of descriptors that have completed but have not yet been written back. That range is a start index plus a count. A write-back request names the range, and it chooses between a status-byte-only write and a full-descriptor write.

Three policies decide when the range is written back:
- An immediate status-only write when no threshold is programmed.
- A full batch write once the number of ready descriptors reaches a programmed threshold.
- A full flush forced by a programmable delay timer. This flush also pulses an interrupt event.

A request is held until the memory side acknowledges it. Completions that arrive in the meantime keep accumulating. The memory transaction itself and the interrupt controller sit outside the block.

Top module: `txwb_sched`

## Requirements
- R1: While reset is applied and just after it, `wb_req` and `wb_irq` are 0. The first request after reset has `wb_start` equal to 0.
- R2: A completion with `wb_thresh` = 0, `cmp_ide` = 0 and `cmp_rs` = 1 leads to a request with `wb_full` = 0 (status byte only). The request rises after the second rising clock edge that follows the completion's edge, counting that edge as the first. The request covers every unwritten descriptor, including that one.
- R3: A completion with `cmp_rs` = 0 and `cmp_ide` = 0 causes no request. The descriptor stays in the accumulated range and is included in the next request's `wb_count`.
- R4: With `wb_thresh` > 0, the report-status flag never triggers a write. No request is made while fewer than `wb_thresh` descriptors are ready. When the count reaches `wb_thresh`, a request with `wb_full` = 1 and `wb_count` equal to that count follows one clock later.
- R5: The first delay-enabled completion of an accumulation loads the timer with `delay_val`. Each cycle with `tick` high counts the timer down by one. When it reaches zero, a full request (`wb_full` = 1) for all accumulated descriptors follows one clock later. `wb_irq` is high for exactly that first cycle of the request.
- R6: With `delay_val` = 0, delay-enabled completions start no timer. No expiry request and no interrupt result from them.
- R7: Each request's `wb_start` equals the previous request's `wb_start` plus its `wb_count`, modulo 2^IDX_W.
- R8: When the threshold is reached and the timer expires in the same cycle, a single full request covers all accumulated descriptors and carries the interrupt pulse.
- R9: A request holds `wb_req`, `wb_start`, `wb_count` and `wb_full` stable until `wb_ack` is sampled high. `wb_req` is then low for at least one cycle. Completions that arrive meanwhile are accumulated and reported in the next request.
- R10: `wb_irq` pulses only together with the rise of a timer-forced request.
- R11: Any request clears the running delay timer. Descriptors already written by a batch therefore never cause a later expiry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmp_valid | input | 1 | One descriptor completed this cycle |
| cmp_rs | input | 1 | Report-status flag of the completed descriptor |
| cmp_ide | input | 1 | Delay-enable flag of the completed descriptor |
| wb_thresh | input | IDX_W+1 | Batch threshold; 0 selects immediate status writes |
| delay_val | input | TMR_W | Delay timer reload value in ticks; 0 disables the timer |
| tick | input | 1 | Timer time base, one count-down per high cycle |
| wb_ack | input | 1 | Memory side accepted the pending request |
| wb_req | output | 1 | Write-back request pending |
| wb_start | output | IDX_W | Ring index of the first descriptor to write |
| wb_count | output | IDX_W+1 | Number of descriptors to write |
| wb_full | output | 1 | 1: full descriptors, 0: status byte only |
| wb_irq | output | 1 | One-cycle interrupt event for a timer-forced flush |

## Verification
On every cycle, the assertions check the request handshake:
- the request fields stay stable while a request waits;
- the request drops after an acknowledge;
- the count is never zero;
- the interrupt is a single-cycle pulse that appears only on the rising edge of a full request;
- a full request raised without the interrupt meets the threshold.

Some behaviours only the bench scenarios can show. These are the exact cycle on which each policy fires, the carrying of non-reporting descriptors into later ranges, and the continuity of start indices. They also include the reload and disable behaviour of the timer and the merging of a coincident threshold and expiry.

// File: rtl/txwb_pkg.sv
package txwb_pkg;

  typedef enum logic {
    WB_STATUS = 1'b0,
    WB_FULL   = 1'b1
  } wb_mode_e;

endpackage

// File: rtl/txwb_accum.sv
// Tracks the oldest unwritten descriptor index and how many are unwritten.
module txwb_accum #(
  parameter int IDX_W = 8,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic             issue,
  output logic [IDX_W-1:0] acc_start,
  output logic [CNT_W-1:0] acc_count
);

  logic [IDX_W-1:0] start_q, start_d;
  logic [CNT_W-1:0] count_q, count_d;
  logic             acc_en;

  always_comb begin
    acc_en  = issue | cmp_valid;
    count_d = (issue ? '0 : count_q) + CNT_W'(cmp_valid);
    start_d = issue ? (start_q + count_q[IDX_W-1:0]) : start_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      count_q <= '0;
    end else if (acc_en) begin
      start_q <= start_d;
      count_q <= count_d;
    end
  end

  assign acc_start = start_q;
  assign acc_count = count_q;

endmodule

// File: rtl/txwb_delay_timer.sv
// Interrupt delay timer: loaded on the first delay-enabled completion,
// counts down on tick, flags expiry until the next write-back clears it.
module txwb_delay_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             tick,
  input  logic             clear,
  input  logic [TMR_W-1:0] delay_val,
  output logic             expired
);

  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             run_q, run_d;
  logic             exp_q, exp_d;
  logic             tmr_en;

  always_comb begin
    cnt_d = cnt_q;
    run_d = run_q;
    exp_d = exp_q;
    if (run_q && tick) begin
      if (cnt_q <= TMR_W'(1)) begin
        cnt_d = '0;
        run_d = 1'b0;
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q - TMR_W'(1);
      end
    end
    if (clear) begin
      cnt_d = '0;
      run_d = 1'b0;
      exp_d = 1'b0;
    end
    if (arm && !run_d && !exp_d && (delay_val != '0)) begin
      cnt_d = delay_val;
      run_d = 1'b1;
    end
    tmr_en = arm | clear | (run_q & tick);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
      exp_q <= 1'b0;
    end else if (tmr_en) begin
      cnt_q <= cnt_d;
      run_q <= run_d;
      exp_q <= exp_d;
    end
  end

  assign expired = exp_q;

endmodule

// File: rtl/txwb_issue.sv
// Chooses the write-back policy, holds the request until acknowledged.
module txwb_issue
  import txwb_pkg::*;
#(
  parameter int IDX_W = 8,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] acc_start,
  input  logic [CNT_W-1:0] acc_count,
  input  logic [CNT_W-1:0] thresh,
  input  logic             expired,
  input  logic             imm_hit,
  input  logic             wb_ack,
  output logic             issue,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_start,
  output logic [CNT_W-1:0] wb_count,
  output logic             wb_full,
  output logic             wb_irq
);

  logic             owe_q, owe_d;
  logic             req_q, req_d;
  logic             irq_q, irq_d;
  logic [IDX_W-1:0] start_r;
  logic [CNT_W-1:0] cnt_r;
  wb_mode_e         mode_r, mode_d;
  logic             batch_hit, full_go;

  always_comb begin
    batch_hit = (thresh != '0) && (acc_count >= thresh);
    full_go   = expired | batch_hit;
    issue     = !req_q && (full_go || owe_q);
    owe_d     = (issue ? 1'b0 : owe_q) | imm_hit;
    req_d     = issue | (req_q & ~wb_ack);
    irq_d     = issue & expired;
    mode_d    = full_go ? WB_FULL : WB_STATUS;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owe_q <= 1'b0;
      req_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      owe_q <= owe_d;
      req_q <= req_d;
      irq_q <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_r <= '0;
      cnt_r   <= '0;
      mode_r  <= WB_STATUS;
    end else if (issue) begin
      start_r <= acc_start;
      cnt_r   <= acc_count;
      mode_r  <= mode_d;
    end
  end

  assign wb_req   = req_q;
  assign wb_start = start_r;
  assign wb_count = cnt_r;
  assign wb_full  = (mode_r == WB_FULL);
  assign wb_irq   = irq_q;

endmodule

// File: rtl/txwb_sched.sv
module txwb_sched #(
  parameter  int IDX_W = 8,
  parameter  int TMR_W = 16,
  localparam int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_valid,
  input  logic             cmp_rs,
  input  logic             cmp_ide,
  input  logic [CNT_W-1:0] wb_thresh,
  input  logic [TMR_W-1:0] delay_val,
  input  logic             tick,
  input  logic             wb_ack,
  output logic             wb_req,
  output logic [IDX_W-1:0] wb_start,
  output logic [CNT_W-1:0] wb_count,
  output logic             wb_full,
  output logic             wb_irq
);

  logic [1:0]       rst_sync_q;
  logic             rst_ni;
  logic             imm_hit, arm, issue, expired;
  logic [IDX_W-1:0] acc_start;
  logic [CNT_W-1:0] acc_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  always_comb begin
    imm_hit = cmp_valid & cmp_rs & ~cmp_ide & (wb_thresh == '0);
    arm     = cmp_valid & cmp_ide;
  end

  txwb_accum #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_accum (
    .clk       (clk),
    .rst_n     (rst_ni),
    .cmp_valid (cmp_valid),
    .issue     (issue),
    .acc_start (acc_start),
    .acc_count (acc_count)
  );

  txwb_delay_timer #(.TMR_W(TMR_W)) u_timer (
    .clk       (clk),
    .rst_n     (rst_ni),
    .arm       (arm),
    .tick      (tick),
    .clear     (issue),
    .delay_val (delay_val),
    .expired   (expired)
  );

  txwb_issue #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_ni),
    .acc_start (acc_start),
    .acc_count (acc_count),
    .thresh    (wb_thresh),
    .expired   (expired),
    .imm_hit   (imm_hit),
    .wb_ack    (wb_ack),
    .issue     (issue),
    .wb_req    (wb_req),
    .wb_start  (wb_start),
    .wb_count  (wb_count),
    .wb_full   (wb_full),
    .wb_irq    (wb_irq)
  );

endmodule

// File: rtl/txwb_chk.sv
module txwb_chk #(
  parameter int IDX_W = 8,
  parameter int CNT_W = IDX_W + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] wb_thresh,
  input logic             wb_ack,
  input logic             wb_req,
  input logic [IDX_W-1:0] wb_start,
  input logic [CNT_W-1:0] wb_count,
  input logic             wb_full,
  input logic             wb_irq
);

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && !wb_ack) |=> (wb_req && $stable(wb_start) && $stable(wb_count) && $stable(wb_full)));

  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_req && wb_ack) |=> !wb_req);

  // R2
  nonzero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |-> (wb_count != '0));

  // R5
  irq_on_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_irq |-> ($rose(wb_req) && wb_full));

  // R10
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_irq |=> !wb_irq);

  // R4
  batch_thresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wb_req) && wb_full && !wb_irq) |-> (($past(wb_thresh) != '0) && (wb_count >= $past(wb_thresh))));

endmodule

bind txwb_sched txwb_chk #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_txwb_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wb_thresh (wb_thresh),
  .wb_ack    (wb_ack),
  .wb_req    (wb_req),
  .wb_start  (wb_start),
  .wb_count  (wb_count),
  .wb_full   (wb_full),
  .wb_irq    (wb_irq)
);

// File: tb/tb_txwb_sched.sv
module tb_txwb_sched;
  localparam int IDX_W = 8;
  localparam int TMR_W = 16;
  localparam int CNT_W = IDX_W + 1;
  localparam int RING  = 1 << IDX_W;

  // vector table: threshold, completions, rs on last, expect request, count, full
  localparam int NV = 6;
  localparam int TV_THR [NV] = '{0, 0, 2, 3, 3, 4};
  localparam int TV_N   [NV] = '{1, 3, 2, 2, 1, 4};
  localparam int TV_RS  [NV] = '{1, 1, 0, 1, 0, 1};
  localparam int TV_REQ [NV] = '{1, 1, 1, 0, 1, 1};
  localparam int TV_CNT [NV] = '{1, 3, 2, 0, 3, 4};
  localparam int TV_FUL [NV] = '{0, 0, 1, 0, 1, 1};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_n;
  logic             cmp_valid, cmp_rs, cmp_ide, tick, wb_ack;
  logic [CNT_W-1:0] wb_thresh;
  logic [TMR_W-1:0] delay_val;
  logic             wb_req, wb_full, wb_irq;
  logic [IDX_W-1:0] wb_start;
  logic [CNT_W-1:0] wb_count;

  txwb_sched #(.IDX_W(IDX_W), .TMR_W(TMR_W)) dut (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_rs(cmp_rs),
    .cmp_ide(cmp_ide), .wb_thresh(wb_thresh), .delay_val(delay_val),
    .tick(tick), .wb_ack(wb_ack), .wb_req(wb_req), .wb_start(wb_start),
    .wb_count(wb_count), .wb_full(wb_full), .wb_irq(wb_irq)
  );

  int checks = 0;
  int fails  = 0;
  int exp_start = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic complete(bit rs, bit ide);
    cmp_valid = 1'b1; cmp_rs = rs; cmp_ide = ide;
    @(negedge clk);
    cmp_valid = 1'b0; cmp_rs = 1'b0; cmp_ide = 1'b0;
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_ack();
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
  endtask

  // checks a visible request, acknowledges it and advances the start index
  task automatic expect_req(string tag, int cnt, bit full, bit irqv);
    check({tag, " req"},   int'(wb_req),   1);
    check({tag, " start"}, int'(wb_start), exp_start);
    check({tag, " count"}, int'(wb_count), cnt);
    check({tag, " full"},  int'(wb_full),  int'(full));
    check({tag, " irq"},   int'(wb_irq),   int'(irqv));
    do_ack();
    check({tag, " drop"},  int'(wb_req),   0);
    exp_start = (exp_start + cnt) % RING;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmp_valid = 1'b0; cmp_rs = 1'b0; cmp_ide = 1'b0;
    tick = 1'b0; wb_ack = 1'b0; wb_thresh = '0; delay_val = '0;
    repeat (3) cyc();
    check("R1 reset req", int'(wb_req), 0);
    check("R1 reset irq", int'(wb_irq), 0);
    rst_n = 1'b1;
    repeat (4) cyc();
    check("R1 idle req", int'(wb_req), 0);

    // table of immediate and batch policies (R2 R3 R4 R7)
    for (int v = 0; v < NV; v++) begin
      wb_thresh = CNT_W'(TV_THR[v]);
      cyc();
      for (int k = 0; k < TV_N[v]; k++)
        complete((k == TV_N[v] - 1) ? TV_RS[v][0] : 1'b0, 1'b0);
      check($sformatf("R2 R4 vec%0d early", v), int'(wb_req), 0);
      cyc();
      if (TV_REQ[v] != 0)
        expect_req($sformatf("R2 R3 R4 R7 vec%0d", v), TV_CNT[v], TV_FUL[v][0], 1'b0);
      else
        check($sformatf("R4 vec%0d rs ignored", v), int'(wb_req), 0);
    end

    // R5 R10: timer flush with interrupt
    wb_thresh = '0; delay_val = TMR_W'(3);
    cyc();
    complete(1'b0, 1'b1);
    pulse_tick(); pulse_tick();
    check("R5 before expiry", int'(wb_req), 0);
    pulse_tick();
    check("R5 expiry edge", int'(wb_req), 0);
    cyc();
    check("R10 irq high", int'(wb_irq), 1);
    check("R5 flush req", int'(wb_req), 1);
    cyc();
    check("R10 irq one cycle", int'(wb_irq), 0);
    expect_req("R5 flush", 1, 1'b1, 1'b0);

    // R8: threshold and expiry in the same cycle
    wb_thresh = CNT_W'(2); delay_val = TMR_W'(1);
    cyc();
    complete(1'b0, 1'b1);
    cmp_valid = 1'b1; tick = 1'b1;
    cyc();
    cmp_valid = 1'b0; tick = 1'b0;
    check("R8 early", int'(wb_req), 0);
    cyc();
    expect_req("R8 merged", 2, 1'b1, 1'b1);
    cyc();
    check("R8 single request", int'(wb_req), 0);

    // R11: batch write clears the running timer
    wb_thresh = CNT_W'(2); delay_val = TMR_W'(5);
    cyc();
    complete(1'b0, 1'b1);
    complete(1'b0, 1'b0);
    cyc();
    expect_req("R11 batch", 2, 1'b1, 1'b0);
    for (int t = 0; t < 6; t++) pulse_tick();
    cyc();
    check("R11 no late flush", int'(wb_req), 0);

    // R6: zero delay disables the timer
    wb_thresh = '0; delay_val = '0;
    cyc();
    complete(1'b0, 1'b1);
    for (int t = 0; t < 4; t++) pulse_tick();
    cyc();
    check("R6 no timer request", int'(wb_req), 0);
    complete(1'b1, 1'b0);
    cyc();
    expect_req("R6 R3 carried", 2, 1'b0, 1'b0);

    // R9: hold until ack, accumulate meanwhile
    complete(1'b1, 1'b0);
    cyc();
    check("R9 req up", int'(wb_req), 1);
    for (int k = 0; k < 3; k++) complete(1'b1, 1'b0);
    check("R9 held req",   int'(wb_req),   1);
    check("R9 held start", int'(wb_start), exp_start);
    check("R9 held count", int'(wb_count), 1);
    do_ack();
    check("R9 gap after ack", int'(wb_req), 0);
    exp_start = (exp_start + 1) % RING;
    cyc();
    expect_req("R9 R7 follow-up", 3, 1'b0, 1'b0);

    repeat (3) cyc();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule